// File: doc/BRIEF.md
# Prioritised Interrupt Controller With Per-Source Sense Selection

This block collects 64 interrupt request lines and presents the most urgent one to a processor. Every source owns a pair of 32-bit configuration words on a simple register bus. The first word holds a two-bit enable and a sense selector. The second word holds an 8-bit priority. A small window of sources, numbers 47 to 50, may be set to rising-edge or falling-edge sensing. For those sources an event is held in a latch until software clears it. All other sources behave as active-high levels.

A global detection switch, a threshold register and an output switch control the request line. Software reads a status register to learn which source won. The number 63 is reserved as the "nothing pending" answer, so source 63 can never be reported. Software services the source, clears its edge latch if it has one, and reads the status again.

Top module: `intc_top`

## Requirements
- R1: After reset all configuration words, the detection switch, the output switch and the threshold read as zero, the status register reads 63 in bits 31:24 and `irq_out` is low.
- R2: Word one of source s is at byte address 0x200+8*s and word two is at 0x204+8*s. Word one keeps bits 29:28 (enable) and 27:24 (sense) and reads zero elsewhere. Word two keeps bits 7:0 (priority) and reads zero elsewhere. Each source has its own storage.
- R3: A source takes part only when both of its enable bits 29:28 are 1. A value of 00, 01 or 10 disables it.
- R4: For sources 47 to 50 the sense code selects the behaviour: 0 is active-low level, 1 is active-high level, 2 is falling edge, 3 is rising edge, and codes 4 to 15 act as active-high level.
- R5: Every source outside 47 to 50 is an active-high level whatever its sense code holds.
- R6: An edge event stays pending after the input returns to rest. It is removed only by writing the clear register at 0x0C0 with bit 8 set and bits 3:0 equal to the source number modulo 16. A write with bit 8 clear, or with a different index, leaves it pending.
- R7: When a new edge on a source and a clear write for that source fall in the same clock cycle, the source stays pending.
- R8: The status register at 0x144 returns in bits 31:24 the eligible source with the largest priority value. Among equal priorities, the lowest source number wins.
- R9: A source is eligible only when its priority is strictly greater than the threshold held in bits 7:0 of 0x084. A threshold of 0 therefore excludes only priority-0 sources.
- R10: When no source is eligible, the status reads 63. Source 63 is never eligible.
- R11: Bit 0 of 0x004 enables detection. When it is clear, no source is eligible and no edge is captured. Bit 0 of 0x444 enables the request line. `irq_out` is high exactly when both bits are set and some source is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe, applied at the clock edge |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | 64 | Raw interrupt request lines, one per source |
| irq_out | output | 1 | Interrupt request toward the processor |

## Verification
The one pair of functions that can meet in a single cycle is the capture of a new edge and the software clear of the same latch. If the clear won, an event would be lost silently. The bench lines up a rising input so that its detection coincides exactly with the clear write, then expects the source to remain reported. A second, lone clear must then remove it. Arbitration is judged by a sweep over twenty patterns of inputs, priorities, enables and thresholds, each compared with an ordered scan computed in the bench.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int BUS_AW = 12;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] ADR_DETECT  = 12'h004;
  localparam logic [BUS_AW-1:0] ADR_THRESH  = 12'h084;
  localparam logic [BUS_AW-1:0] ADR_EDGECLR = 12'h0C0;
  localparam logic [BUS_AW-1:0] ADR_STATUS  = 12'h144;
  localparam logic [BUS_AW-1:0] ADR_OUTEN   = 12'h444;

  // configuration window occupies 0x200..0x3FF
  localparam logic [2:0] CFG_WIN = 3'b001;

  typedef enum logic [3:0] {
    SN_LEVEL_LO = 4'h0,
    SN_LEVEL_HI = 4'h1,
    SN_FALL     = 4'h2,
    SN_RISE     = 4'h3
  } sense_e;

  // a source is live only when both enable bits are set
  function automatic logic src_enabled(input logic [1:0] en2);
    return en2 == 2'b11;
  endfunction

  function automatic logic is_edge_code(input logic [3:0] sn);
    return (sn == SN_FALL) || (sn == SN_RISE);
  endfunction

  // pending state of an edge-capable source
  function automatic logic edge_src_pending(input logic [3:0] sn,
                                            input logic lvl,
                                            input logic held);
    logic r;
    case (sn)
      SN_LEVEL_LO:     r = ~lvl;
      SN_FALL, SN_RISE: r = held;
      default:         r = lvl;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int PRIO_W = 8,
  parameter int IDX_W  = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [BUS_AW-1:0]      bus_addr,
  input  logic [BUS_DW-1:0]      bus_wdata,
  output logic [BUS_DW-1:0]      bus_rdata,
  input  logic [IDX_W-1:0]       status_code,
  output logic                   det_en,
  output logic                   out_en,
  output logic [PRIO_W-1:0]      mask_lvl,
  output logic [2*NSRC-1:0]      cfg_en2,
  output logic [4*NSRC-1:0]      cfg_sense,
  output logic [PRIO_W*NSRC-1:0] cfg_prio,
  output logic                   clr_pulse,
  output logic [3:0]             clr_idx
);

  logic [1:0]        en_q [NSRC];
  logic [3:0]        sn_q [NSRC];
  logic [PRIO_W-1:0] pr_q [NSRC];

  logic              cfg_hit;
  logic              word_b;
  logic [IDX_W-1:0]  cfg_src;
  logic              unused_wdata;

  assign cfg_hit = (bus_addr[BUS_AW-1:9] == CFG_WIN) && (bus_addr[1:0] == 2'b00);
  assign word_b  = bus_addr[2];
  assign cfg_src = bus_addr[3 +: IDX_W];
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_en   <= 1'b0;
      out_en   <= 1'b0;
      mask_lvl <= '0;
      for (int s = 0; s < NSRC; s++) begin
        en_q[s] <= 2'b00;
        sn_q[s] <= 4'h0;
        pr_q[s] <= '0;
      end
    end else if (bus_we) begin
      if (cfg_hit) begin
        if (word_b) begin
          pr_q[cfg_src] <= bus_wdata[PRIO_W-1:0];
        end else begin
          en_q[cfg_src] <= bus_wdata[29:28];
          sn_q[cfg_src] <= bus_wdata[27:24];
        end
      end else begin
        case (bus_addr)
          ADR_DETECT: det_en   <= bus_wdata[0];
          ADR_THRESH: mask_lvl <= bus_wdata[PRIO_W-1:0];
          ADR_OUTEN:  out_en   <= bus_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // edge clear is a write-only strobe acting in the write cycle
  assign clr_pulse = bus_we && (bus_addr == ADR_EDGECLR) && bus_wdata[8];
  assign clr_idx   = bus_wdata[3:0];

  for (genvar s = 0; s < NSRC; s++) begin : g_flat
    assign cfg_en2[2*s +: 2]           = en_q[s];
    assign cfg_sense[4*s +: 4]         = sn_q[s];
    assign cfg_prio[PRIO_W*s +: PRIO_W] = pr_q[s];
  end

  always_comb begin
    bus_rdata = '0;
    if (cfg_hit) begin
      if (word_b) begin
        bus_rdata[PRIO_W-1:0] = pr_q[cfg_src];
      end else begin
        bus_rdata[29:28] = en_q[cfg_src];
        bus_rdata[27:24] = sn_q[cfg_src];
      end
    end else begin
      case (bus_addr)
        ADR_DETECT: bus_rdata[0]            = det_en;
        ADR_THRESH: bus_rdata[PRIO_W-1:0]   = mask_lvl;
        ADR_STATUS: bus_rdata[24 +: IDX_W]  = status_code;
        ADR_OUTEN:  bus_rdata[0]            = out_en;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/intc_detect.sv
module intc_detect
  import intc_pkg::*;
#(
  parameter int NSRC    = 64,
  parameter int EDGE_LO = 47,
  parameter int EDGE_HI = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              det_en,
  input  logic [4*NSRC-1:0] cfg_sense,
  input  logic              clr_pulse,
  input  logic [3:0]        clr_idx,
  output logic [NSRC-1:0]   pending,
  output logic [NSRC-1:0]   latch_vec,
  output logic [NSRC-1:0]   edge_evt,
  output logic [NSRC-1:0]   clr_hit,
  output logic [NSRC-1:0]   edge_mode
);

  logic [NSRC-1:0] in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= irq_in;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int S = s;
    logic [3:0] sn;
    assign sn = cfg_sense[4*S +: 4];

    if (S >= EDGE_LO && S <= EDGE_HI) begin : g_edge
      logic prev_q;
      logic held_q;
      logic rise, fall;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= in_q[S];
      end

      assign rise         = in_q[S] & ~prev_q;
      assign fall         = ~in_q[S] & prev_q;
      assign edge_mode[S] = is_edge_code(sn);
      assign edge_evt[S]  = det_en & edge_mode[S] & ((sn == SN_RISE) ? rise : fall);
      assign clr_hit[S]   = clr_pulse & (clr_idx == 4'(S % 16));

      // a new event outranks a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= edge_evt[S] | (held_q & ~clr_hit[S] & edge_mode[S]);
      end

      assign latch_vec[S] = held_q;
      assign pending[S]   = edge_src_pending(sn, in_q[S], held_q);
    end else begin : g_level
      logic unused_sn;
      assign unused_sn    = ^sn;
      assign edge_mode[S] = 1'b0;
      assign edge_evt[S]  = 1'b0;
      assign clr_hit[S]   = 1'b0;
      assign latch_vec[S] = 1'b0;
      assign pending[S]   = in_q[S];
    end
  end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NSRC   = 64,
  parameter int PRIO_W = 8,
  parameter int IDX_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        elig,
  input  logic [PRIO_W*NSRC-1:0] prio_flat,
  output logic                   win_valid,
  output logic [IDX_W-1:0]       win_idx,
  output logic [PRIO_W-1:0]      win_prio
);

  localparam int LVLS = $clog2(NSRC);

  // right (higher-numbered) half wins only with a strictly larger priority
  function automatic logic right_wins(input logic lv, input logic rv,
                                      input logic [PRIO_W-1:0] lp,
                                      input logic [PRIO_W-1:0] rp);
    return rv && (!lv || (rp > lp));
  endfunction

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int W = NSRC >> l;
    logic [W-1:0]      v;
    logic [PRIO_W-1:0] p  [W];
    logic [IDX_W-1:0]  ix [W];

    if (l == 0) begin : g_leaf
      for (genvar k = 0; k < W; k++) begin : g_k
        assign v[k]  = elig[k];
        assign p[k]  = prio_flat[PRIO_W*k +: PRIO_W];
        assign ix[k] = IDX_W'(k);
      end
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_k
        logic pick_r;
        assign pick_r = right_wins(g_lvl[l-1].v[2*k], g_lvl[l-1].v[2*k+1],
                                   g_lvl[l-1].p[2*k], g_lvl[l-1].p[2*k+1]);
        assign v[k]  = g_lvl[l-1].v[2*k] | g_lvl[l-1].v[2*k+1];
        assign p[k]  = pick_r ? g_lvl[l-1].p[2*k+1]  : g_lvl[l-1].p[2*k];
        assign ix[k] = pick_r ? g_lvl[l-1].ix[2*k+1] : g_lvl[l-1].ix[2*k];
      end
    end
  end

  assign win_valid = g_lvl[LVLS].v[0];
  assign win_idx   = g_lvl[LVLS].ix[0];
  assign win_prio  = g_lvl[LVLS].p[0];

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NSRC    = 64,
  parameter int PRIO_W  = 8,
  parameter int EDGE_LO = 47,
  parameter int EDGE_HI = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NSRC-1:0]  irq_in,
  output logic             irq_out
);

  localparam int IDX_W = $clog2(NSRC);
  localparam logic [IDX_W-1:0] NONE_CODE = IDX_W'(NSRC - 1);

  logic                   det_en, out_en;
  logic [PRIO_W-1:0]      mask_lvl;
  logic [2*NSRC-1:0]      cfg_en2;
  logic [4*NSRC-1:0]      cfg_sense;
  logic [PRIO_W*NSRC-1:0] cfg_prio;
  logic                   clr_pulse;
  logic [3:0]             clr_idx;
  logic [NSRC-1:0]        pending, latch_vec, edge_evt, clr_hit, edge_mode;
  logic [NSRC-1:0]        elig;
  logic                   win_valid;
  logic [IDX_W-1:0]       win_idx;
  logic [PRIO_W-1:0]      win_prio;
  logic [IDX_W-1:0]       status_code;

  intc_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .status_code (status_code),
    .det_en      (det_en),
    .out_en      (out_en),
    .mask_lvl    (mask_lvl),
    .cfg_en2     (cfg_en2),
    .cfg_sense   (cfg_sense),
    .cfg_prio    (cfg_prio),
    .clr_pulse   (clr_pulse),
    .clr_idx     (clr_idx)
  );

  intc_detect #(.NSRC(NSRC), .EDGE_LO(EDGE_LO), .EDGE_HI(EDGE_HI)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .det_en    (det_en),
    .cfg_sense (cfg_sense),
    .clr_pulse (clr_pulse),
    .clr_idx   (clr_idx),
    .pending   (pending),
    .latch_vec (latch_vec),
    .edge_evt  (edge_evt),
    .clr_hit   (clr_hit),
    .edge_mode (edge_mode)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_elig
    if (s == NSRC - 1) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^{cfg_en2[2*s +: 2], cfg_prio[PRIO_W*s +: PRIO_W], pending[s]};
      assign elig[s] = 1'b0;
    end else begin : g_live
      assign elig[s] = det_en
                     & src_enabled(cfg_en2[2*s +: 2])
                     & pending[s]
                     & (cfg_prio[PRIO_W*s +: PRIO_W] > mask_lvl);
    end
  end

  intc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .elig      (elig),
    .prio_flat (cfg_prio),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  assign status_code = win_valid ? win_idx : NONE_CODE;
  assign irq_out     = out_en & win_valid;

endmodule

// File: rtl/intc_checks.sv
module intc_checks #(
  parameter int NSRC    = 64,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 6,
  parameter int EDGE_LO = 47,
  parameter int EDGE_HI = 50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_out,
  input logic              det_en,
  input logic              out_en,
  input logic [NSRC-1:0]   elig,
  input logic              win_valid,
  input logic [IDX_W-1:0]  win_idx,
  input logic [PRIO_W-1:0] win_prio,
  input logic [PRIO_W-1:0] mask_lvl,
  input logic [IDX_W-1:0]  status_code,
  input logic [NSRC-1:0]   latch_vec,
  input logic [NSRC-1:0]   edge_evt,
  input logic [NSRC-1:0]   clr_hit,
  input logic [NSRC-1:0]   edge_mode
);

  logic unused_chk;
  assign unused_chk = ^{latch_vec, edge_evt, clr_hit, edge_mode};

  a_r11_out_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (det_en && out_en));

  a_r11_det_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |-> (elig == '0));

  a_r8_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (elig != '0) |-> (win_valid && elig[win_idx]));

  a_r9_winner_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_prio > mask_lvl));

  a_r10_none_code: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> (status_code == IDX_W'(NSRC - 1)));

  a_r10_reserved_never_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    !elig[NSRC-1]);

  for (genvar s = EDGE_LO; s <= EDGE_HI; s++) begin : g_edge_chk
    a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_vec[s] && edge_mode[s] && !clr_hit[s]) |=> latch_vec[s]);

    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[s] && !edge_evt[s]) |=> !latch_vec[s]);

    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[s] |=> latch_vec[s]);
  end

endmodule

bind intc_top intc_checks #(
  .NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W),
  .EDGE_LO(EDGE_LO), .EDGE_HI(EDGE_HI)
) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_out     (irq_out),
  .det_en      (det_en),
  .out_en      (out_en),
  .elig        (elig),
  .win_valid   (win_valid),
  .win_idx     (win_idx),
  .win_prio    (win_prio),
  .mask_lvl    (mask_lvl),
  .status_code (status_code),
  .latch_vec   (latch_vec),
  .edge_evt    (edge_evt),
  .clr_hit     (clr_hit),
  .edge_mode   (edge_mode)
);

// File: tb/sim_intc_top.sv
`timescale 1ns/1ps
module sim_intc_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_in = '0;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intc_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .irq_out   (irq_out)
  );

  localparam logic [11:0] DET = 12'h004, THR = 12'h084, CLR = 12'h0C0,
                          STA = 12'h144, OEN = 12'h444;

  function automatic logic [11:0] wa(input int s);
    return 12'(12'h200 + 8 * s);
  endfunction
  function automatic logic [11:0] wb(input int s);
    return 12'(12'h204 + 8 * s);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_status(input string tag, input int exp);
    logic [31:0] v;
    rd(STA, v);
    chk(tag, {24'h0, v[31:24]}, 32'(exp));
  endtask

  function automatic int pf(input int s, input int t);
    return (s * 7 + t * 13) % 11;
  endfunction
  function automatic logic [31:0] enc(input int s, input int t);
    if ((s + t) % 5 == 0) return 32'h2100_0000;
    if ((s + t) % 7 == 0) return 32'h0000_0000;
    return 32'h3100_0000;
  endfunction
  function automatic bit live(input int s, input int t);
    return enc(s, t) == 32'h3100_0000;
  endfunction
  function automatic bit pat(input int s, input int t);
    return ((s * s + 3 * t + s * t) % 3) != 0;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_status("R1 status", 63);
    chk("R1 irq_out", {31'h0, irq_out}, 32'h0);
    rd(wa(5), v);  chk("R1 cfgA", v, 32'h0);
    rd(wb(60), v); chk("R1 cfgB", v, 32'h0);
    rd(DET, v);    chk("R1 detect", v, 32'h0);

    // R2 readback sweep: write all, then read all
    for (int s = 0; s < 64; s++) begin
      wr(wa(s), 32'hC0FF_FFFF ^ (32'(s) * 32'h0101_0101));
      wr(wb(s), 32'(s) * 32'h0203_0405 + 32'd1);
    end
    for (int s = 0; s < 64; s++) begin
      rd(wa(s), v);
      chk($sformatf("R2 wordA src%0d", s), v,
          (32'hC0FF_FFFF ^ (32'(s) * 32'h0101_0101)) & 32'h3F00_0000);
      rd(wb(s), v);
      chk($sformatf("R2 wordB src%0d", s), v,
          (32'(s) * 32'h0203_0405 + 32'd1) & 32'h0000_00FF);
    end

    // R3 R5 R8 R9 R11 arbitration sweep
    wr(DET, 32'h1);
    wr(OEN, 32'h1);
    for (int t = 0; t < 20; t++) begin
      int m, best, bp;
      m = (t % 4) * 2;
      wr(THR, 32'(m));
      for (int s = 0; s < 64; s++) begin
        wr(wa(s), enc(s, t));
        wr(wb(s), 32'(pf(s, t)));
      end
      for (int s = 0; s < 64; s++) irq_in[s] = pat(s, t);
      settle();
      best = -1; bp = -1;
      for (int s = 0; s < 63; s++)
        if (live(s, t) && pat(s, t) && pf(s, t) > m && pf(s, t) > bp) begin
          best = s; bp = pf(s, t);
        end
      chk_status($sformatf("R8 sweep t%0d", t), (best < 0) ? 63 : best);
      chk($sformatf("R11 sweep irq t%0d", t), {31'h0, irq_out}, (best < 0) ? 32'h0 : 32'h1);
    end

    // quiet all sources for directed cases
    irq_in = '0;
    wr(THR, 32'h0);
    for (int s = 0; s < 64; s++) begin
      wr(wa(s), 32'h3100_0000);
      wr(wb(s), 32'h0);
    end

    // R5 non-edge source ignores sense code 0
    wr(wa(10), 32'h3000_0000); wr(wb(10), 32'h5);
    settle(); chk_status("R5 low input idle", 63);
    irq_in[10] = 1'b1; settle(); chk_status("R5 high input pending", 10);
    irq_in[10] = 1'b0; wr(wb(10), 32'h0);

    // R4 level-low on source 48
    wr(wa(48), 32'h3000_0000); wr(wb(48), 32'h5);
    settle(); chk_status("R4 level low active", 48);
    irq_in[48] = 1'b1; settle(); chk_status("R4 level low idle", 63);
    irq_in[48] = 1'b0; wr(wb(48), 32'h0);

    // R4 R6 rising on source 49 (index 1)
    wr(wa(49), 32'h3300_0000); wr(wb(49), 32'h6);
    settle(); chk_status("R4 rising no event", 63);
    irq_in[49] = 1'b1; @(negedge clk); irq_in[49] = 1'b0;
    settle(); chk_status("R4 rising latched", 49);
    wr(CLR, 32'h0000_0001); settle(); chk_status("R6 clear without bit8", 49);
    wr(CLR, 32'h0000_0102); settle(); chk_status("R6 clear other index", 49);
    wr(CLR, 32'h0000_0101); settle(); chk_status("R6 clear matching", 63);
    wr(wb(49), 32'h0);

    // R4 R6 falling on source 47 (index 15)
    wr(wa(47), 32'h3200_0000); wr(wb(47), 32'h6);
    irq_in[47] = 1'b1; settle(); chk_status("R4 falling ignores rise", 63);
    irq_in[47] = 1'b0; settle(); chk_status("R4 falling latched", 47);
    wr(CLR, 32'h0000_010F); settle(); chk_status("R6 clear index 15", 63);
    wr(wb(47), 32'h0);

    // R7 new edge coincides with clear (source 48, index 0)
    wr(wa(48), 32'h3300_0000); wr(wb(48), 32'h7);
    settle();
    irq_in[48] = 1'b1; settle(); chk_status("R7 first edge", 48);
    irq_in[48] = 1'b0; settle(); chk_status("R7 held after release", 48);
    irq_in[48] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr(CLR, 32'h0000_0100);
    settle(); chk_status("R7 edge beats clear", 48);
    wr(CLR, 32'h0000_0100); settle(); chk_status("R7 lone clear", 63);
    irq_in[48] = 1'b0; wr(wb(48), 32'h0); settle();

    // R10 reserved source 63
    wr(wb(63), 32'h9); irq_in[63] = 1'b1; settle();
    chk_status("R10 reserved not reported", 63);
    chk("R10 reserved no irq", {31'h0, irq_out}, 32'h0);
    irq_in[63] = 1'b0;

    // R11 global switches
    wr(wb(20), 32'h4); irq_in[20] = 1'b1; settle();
    chk_status("R11 both on status", 20);
    chk("R11 both on irq", {31'h0, irq_out}, 32'h1);
    wr(OEN, 32'h0); settle();
    chk("R11 output off irq", {31'h0, irq_out}, 32'h0);
    chk_status("R11 output off status", 20);
    wr(OEN, 32'h1); wr(DET, 32'h0); settle();
    chk("R11 detect off irq", {31'h0, irq_out}, 32'h0);
    chk_status("R11 detect off status", 63);
    wr(wa(50), 32'h3300_0000); wr(wb(50), 32'h8);
    irq_in[50] = 1'b1; settle(); irq_in[50] = 1'b0;
    wr(DET, 32'h1); settle();
    chk_status("R11 edge not captured while off", 20);
    rd(DET, v); chk("R11 detect readback", v, 32'h1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule